// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block is the data-hazard control for an in-order pipeline with five stages (fetch, decode, execute, memory, write-back). Register reads happen only in decode and register writes only in write-back, so the only hazard it has to resolve is a read of a register that an older instruction has not yet written back. For each of the two ALU operands of the instruction in execute, it produces a multiplexer select. The select chooses the register-file value, the result held in the execute/memory pipeline register, or the result held in the memory/write-back pipeline register.

A load in execute cannot pass its data forward to the instruction right behind it. When the instruction in decode reads the load's target register, the unit raises a hold signal and a bubble signal. The hold signal freezes the program counter and the fetch/decode register. The bubble signal loads a no-op, with register write and memory write cleared, into the decode/execute register. After that single bubble the loaded value sits in memory/write-back and reaches the dependent instruction through the ordinary forwarding path. The unit also decodes the decode-stage instruction word to report which register field names its destination.

The block is purely combinational. Field positions, opcode values, the hard-wired zero register and whether the rt-use decode is exact are all parameters.

Top module: `hzu_fwd_unit`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register file, 2'b10 for the execute/memory result and 2'b01 for the memory/write-back result. The code 2'b11 never appears.
- R2: Operand A (source `ex_rs`) selects 2'b10 when `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `ex_rs`.
- R3: An operand selects 2'b01 when `mwb_wen` is 1, `mwb_dst` is nonzero and equal to its source, and the execute/memory stage does not match. This includes the cycle after a load-use bubble, when the loaded value sits in memory/write-back.
- R4: When both stages match the same source register, the execute/memory result (2'b10) wins.
- R5: Register 0 never causes forwarding or a stall. A source of 0 always selects 2'b00, and a load targeting register 0 never stalls.
- R6: A stage whose write enable is 0 never matches, whatever its destination field holds.
- R7: `hold_front` and `bubble_idex` are 1 when `ex_is_load` is 1, `ex_rt` is nonzero, and `ex_rt` equals either the rs field (bits 25..21) of `id_instr` or its rt field (bits 20..16) when that instruction reads rt.
- R8: `hold_front` and `bubble_idex` are always equal, and both are 0 whenever `ex_is_load` is 0.
- R9: The decode-stage instruction reads its rt field only for opcode (bits 31..26) 6'h00 (register-register), 6'h2B (store), 6'h04 and 6'h05 (branches). For any other opcode, such as 6'h08 (add immediate) or 6'h23 (load), a match on rt alone does not stall.
- R10: `id_dst` is the rd field (bits 15..11) of `id_instr` when its opcode is 6'h00, and the rt field (bits 20..16) otherwise.
- R11: Operand A's select depends only on `ex_rs` and operand B's only on `ex_rt`, so the two can pick different stages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction word in the decode stage |
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second source register of the instruction in execute (also a load's target) |
| ex_is_load | input | 1 | Instruction in execute is a load |
| exm_dst | input | 5 | Destination register held in the execute/memory register |
| exm_wen | input | 1 | Register write enable held in the execute/memory register |
| mwb_dst | input | 5 | Destination register held in the memory/write-back register |
| mwb_wen | input | 1 | Register write enable held in the memory/write-back register |
| sel_a | output | 2 | Source select for ALU operand A |
| sel_b | output | 2 | Source select for ALU operand B |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode register |
| bubble_idex | output | 1 | Load a no-op into the decode/execute register |
| id_dst | output | 5 | Destination register field of the decode-stage instruction |

## Verification
Some rules are checked on every evaluation:
- no illegal select code appears;
- a select names a stage only when that stage is enabled and its destination matches a nonzero source;
- execute/memory wins over memory/write-back;
- register 0 never forwards;
- a stall only appears with a load in execute that targets a nonzero register.

Other behaviour can only be shown by the bench's scenarios:
- which decode-stage formats stall on an rt match;
- which field is reported as the destination;
- that the value is picked up from memory/write-back after the bubble;
- that the two operands select independently.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_EXM = 2'b10
   } opnd_src_e;
endpackage

// File: rtl/hzu_decode.sv
module hzu_decode #(
   parameter int INSTR_W     = 32,
   parameter int REG_AW      = 5,
   parameter int OP_W        = 6,
   parameter int OP_LSB      = 26,
   parameter int RS_LSB      = 21,
   parameter int RT_LSB      = 16,
   parameter int RD_LSB      = 11,
   parameter logic [5:0] OP_RTYPE = 6'h00,
   parameter logic [5:0] OP_STORE = 6'h2B,
   parameter logic [5:0] OP_BEQ   = 6'h04,
   parameter logic [5:0] OP_BNE   = 6'h05,
   parameter bit PRECISE_USE = 1'b1
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [REG_AW-1:0]  rs,
   output logic [REG_AW-1:0]  rt,
   output logic [REG_AW-1:0]  dst,
   output logic               reads_rt
);
   logic [OP_W-1:0] op;
   logic            is_rtype;

   assign op       = instr[OP_LSB +: OP_W];
   assign rs       = instr[RS_LSB +: REG_AW];
   assign rt       = instr[RT_LSB +: REG_AW];
   assign is_rtype = (op == OP_RTYPE[OP_W-1:0]);

   // register-register writes rd; immediate formats write rt
   assign dst = is_rtype ? instr[RD_LSB +: REG_AW] : rt;

   generate
      if (PRECISE_USE) begin : g_exact
         assign reads_rt = is_rtype
                        || (op == OP_STORE[OP_W-1:0])
                        || (op == OP_BEQ[OP_W-1:0])
                        || (op == OP_BNE[OP_W-1:0]);
      end else begin : g_conservative
         assign reads_rt = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/hzu_operand_sel.sv
module hzu_operand_sel
   import hzu_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              exm_wen,
   input  logic [REG_AW-1:0] mwb_dst,
   input  logic              mwb_wen,
   output opnd_src_e         sel
);
   logic src_live;
   logic hit_exm;
   logic hit_wb;

   generate
      if (ZERO_IS_CONST) begin : g_zero_const
         assign src_live = |src;
      end else begin : g_zero_plain
         assign src_live = 1'b1;
      end
   endgenerate

   assign hit_exm = src_live && exm_wen && (exm_dst == src);
   assign hit_wb  = src_live && mwb_wen && (mwb_dst == src);

   always_comb begin
      if (hit_exm)     sel = SRC_EXM;
      else if (hit_wb) sel = SRC_WB;
      else             sel = SRC_RF;
   end
endmodule

// File: rtl/hzu_loaduse.sv
module hzu_loaduse #(
   parameter int REG_AW        = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic              id_reads_rt,
   output logic              stall
);
   logic tgt_live;

   generate
      if (ZERO_IS_CONST) begin : g_zero_const
         assign tgt_live = |ex_rt;
      end else begin : g_zero_plain
         assign tgt_live = 1'b1;
      end
   endgenerate

   assign stall = ex_is_load && tgt_live
               && ((ex_rt == id_rs) || (id_reads_rt && (ex_rt == id_rt)));
endmodule

// File: rtl/hzu_fwd_unit.sv
module hzu_fwd_unit
   import hzu_pkg::*;
#(
   parameter int INSTR_W       = 32,
   parameter int REG_AW        = 5,
   parameter int OP_LSB        = 26,
   parameter int RS_LSB        = 21,
   parameter int RT_LSB        = 16,
   parameter int RD_LSB        = 11,
   parameter bit ZERO_IS_CONST = 1'b1,
   parameter bit PRECISE_USE   = 1'b1
) (
   input  logic [INSTR_W-1:0] id_instr,
   input  logic [REG_AW-1:0]  ex_rs,
   input  logic [REG_AW-1:0]  ex_rt,
   input  logic               ex_is_load,
   input  logic [REG_AW-1:0]  exm_dst,
   input  logic               exm_wen,
   input  logic [REG_AW-1:0]  mwb_dst,
   input  logic               mwb_wen,
   output logic [1:0]         sel_a,
   output logic [1:0]         sel_b,
   output logic               hold_front,
   output logic               bubble_idex,
   output logic [REG_AW-1:0]  id_dst
);
   localparam int OP_W    = INSTR_W - OP_LSB;
   localparam int N_OPND  = 2;

   generate
      if (OP_W != 6) begin : g_bad_op
         $error("opcode field must be 6 bits wide");
      end
      if (RS_LSB + REG_AW > OP_LSB || RT_LSB + REG_AW > RS_LSB
          || RD_LSB + REG_AW > RT_LSB) begin : g_bad_fields
         $error("register fields overlap");
      end
   endgenerate

   logic [REG_AW-1:0] id_rs;
   logic [REG_AW-1:0] id_rt;
   logic              id_reads_rt;
   logic              stall;
   logic [REG_AW-1:0] opnd_src [N_OPND];
   opnd_src_e         opnd_sel [N_OPND];

   hzu_decode #(
      .INSTR_W (INSTR_W), .REG_AW (REG_AW), .OP_W (OP_W),
      .OP_LSB (OP_LSB), .RS_LSB (RS_LSB), .RT_LSB (RT_LSB), .RD_LSB (RD_LSB),
      .PRECISE_USE (PRECISE_USE)
   ) u_dec (
      .instr    (id_instr),
      .rs       (id_rs),
      .rt       (id_rt),
      .dst      (id_dst),
      .reads_rt (id_reads_rt)
   );

   assign opnd_src[0] = ex_rs;
   assign opnd_src[1] = ex_rt;

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
         hzu_operand_sel #(
            .REG_AW (REG_AW), .ZERO_IS_CONST (ZERO_IS_CONST)
         ) u_sel (
            .src     (opnd_src[g]),
            .exm_dst (exm_dst),
            .exm_wen (exm_wen),
            .mwb_dst (mwb_dst),
            .mwb_wen (mwb_wen),
            .sel     (opnd_sel[g])
         );
      end
   endgenerate

   assign sel_a = opnd_sel[0];
   assign sel_b = opnd_sel[1];

   hzu_loaduse #(
      .REG_AW (REG_AW), .ZERO_IS_CONST (ZERO_IS_CONST)
   ) u_lu (
      .ex_is_load  (ex_is_load),
      .ex_rt       (ex_rt),
      .id_rs       (id_rs),
      .id_rt       (id_rt),
      .id_reads_rt (id_reads_rt),
      .stall       (stall)
   );

   // one stall drives both the front-end freeze and the bubble
   assign hold_front  = stall;
   assign bubble_idex = stall;
endmodule

// File: rtl/hzu_checker.sv
module hzu_checker #(
   parameter int REG_AW = 5
) (
   input logic [REG_AW-1:0] ex_rs,
   input logic [REG_AW-1:0] ex_rt,
   input logic              ex_is_load,
   input logic [REG_AW-1:0] exm_dst,
   input logic              exm_wen,
   input logic [REG_AW-1:0] mwb_dst,
   input logic              mwb_wen,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b,
   input logic              hold_front,
   input logic              bubble_idex
);
   always_comb begin
      p_sel_legal_r1: assert (sel_a != 2'b11 && sel_b != 2'b11)
         else $error("illegal operand select code");
      p_exm_src_r2: assert (sel_a != 2'b10 || (exm_wen && exm_dst == ex_rs && ex_rs != '0))
         else $error("operand A took execute/memory without a match");
      p_wb_src_r3: assert (sel_b != 2'b01 || (mwb_wen && mwb_dst == ex_rt && ex_rt != '0))
         else $error("operand B took write-back without a match");
      p_prio_r4: assert (!(exm_wen && exm_dst == ex_rs && ex_rs != '0) || sel_a == 2'b10)
         else $error("execute/memory lost priority");
      p_zero_r5: assert ((ex_rs != '0 || sel_a == 2'b00) && (ex_rt != '0 || sel_b == 2'b00))
         else $error("register 0 forwarded");
      p_wen_r6: assert (exm_wen || mwb_wen || (sel_a == 2'b00 && sel_b == 2'b00))
         else $error("disabled stage matched");
      p_stall_pair_r8: assert (hold_front == bubble_idex)
         else $error("hold and bubble disagree");
      p_stall_src_r7: assert (!hold_front || (ex_is_load && ex_rt != '0))
         else $error("stall without a nonzero load target");
   end
endmodule

bind hzu_fwd_unit hzu_checker #(.REG_AW (REG_AW)) u_chk (
   .ex_rs       (ex_rs),
   .ex_rt       (ex_rt),
   .ex_is_load  (ex_is_load),
   .exm_dst     (exm_dst),
   .exm_wen     (exm_wen),
   .mwb_dst     (mwb_dst),
   .mwb_wen     (mwb_wen),
   .sel_a       (sel_a),
   .sel_b       (sel_b),
   .hold_front  (hold_front),
   .bubble_idex (bubble_idex)
);

// File: tb/hzu_fwd_unit_tb.sv
module hzu_fwd_unit_tb;
   logic        clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [31:0] id_instr;
   logic [4:0]  ex_rs, ex_rt, exm_dst, mwb_dst, id_dst;
   logic        ex_is_load, exm_wen, mwb_wen, hold_front, bubble_idex;
   logic [1:0]  sel_a, sel_b;

   int n_chk = 0;
   int n_bad = 0;

   hzu_fwd_unit u_dut (
      .id_instr (id_instr), .ex_rs (ex_rs), .ex_rt (ex_rt), .ex_is_load (ex_is_load),
      .exm_dst (exm_dst), .exm_wen (exm_wen), .mwb_dst (mwb_dst), .mwb_wen (mwb_wen),
      .sel_a (sel_a), .sel_b (sel_b), .hold_front (hold_front),
      .bubble_idex (bubble_idex), .id_dst (id_dst)
   );

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                      input logic [4:0] b, input logic [4:0] c);
      return {op, a, b, c, 11'h020};
   endfunction

   typedef struct packed {
      logic [31:0] instr;
      logic [4:0]  ers, ert;
      logic        ld;
      logic [4:0]  xd;
      logic        xw;
      logic [4:0]  wd;
      logic        ww;
      logic [1:0]  ea, eb;
      logic        es;
      logic [4:0]  ed;
   } tv_t;

   localparam int NV = 15;
   localparam tv_t TBL [NV] = '{
      // R10: register-register destination is rd
      '{mk(6'h00,5'd1,5'd2,5'd3), 5'd4, 5'd5, 1'b0, 5'd6, 1'b1, 5'd7, 1'b1, 2'b00, 2'b00, 1'b0, 5'd3},
      // R2 on A, R3 on B, R11 independent
      '{mk(6'h00,5'd1,5'd2,5'd3), 5'd4, 5'd5, 1'b0, 5'd4, 1'b1, 5'd5, 1'b1, 2'b10, 2'b01, 1'b0, 5'd3},
      // R4 both stages match
      '{mk(6'h00,5'd1,5'd2,5'd3), 5'd9, 5'd9, 1'b0, 5'd9, 1'b1, 5'd9, 1'b1, 2'b10, 2'b10, 1'b0, 5'd3},
      // R5 register 0
      '{mk(6'h00,5'd1,5'd2,5'd3), 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 5'd3},
      // R6 enables low
      '{mk(6'h00,5'd1,5'd2,5'd3), 5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8, 1'b0, 2'b00, 2'b00, 1'b0, 5'd3},
      // R6 only write-back enabled
      '{mk(6'h00,5'd1,5'd2,5'd3), 5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8, 1'b1, 2'b01, 2'b01, 1'b0, 5'd3},
      // R7 load-use on rs
      '{mk(6'h00,5'd10,5'd11,5'd12), 5'd1, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 5'd12},
      // R7 load-use on rt of register-register
      '{mk(6'h00,5'd11,5'd10,5'd12), 5'd1, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 5'd12},
      // R9 store reads rt; R10 destination field is rt
      '{mk(6'h2B,5'd3,5'd10,5'd0), 5'd1, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 5'd10},
      // R9 add immediate does not read rt
      '{mk(6'h08,5'd3,5'd10,5'd0), 5'd1, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd10},
      // R9 branch reads rt
      '{mk(6'h04,5'd2,5'd10,5'd0), 5'd1, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 5'd10},
      // R5 load into register 0
      '{mk(6'h00,5'd0,5'd0,5'd5), 5'd1, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd5},
      // R8 no load, no stall
      '{mk(6'h00,5'd10,5'd10,5'd5), 5'd1, 5'd10, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd5},
      // R7 load followed by load using rs; R9 load's rt not a source
      '{mk(6'h23,5'd10,5'd4,5'd0), 5'd1, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 5'd4},
      // R3 after the bubble the loaded value comes from write-back
      '{mk(6'h00,5'd1,5'd2,5'd3), 5'd10, 5'd11, 1'b0, 5'd11, 1'b1, 5'd10, 1'b1, 2'b01, 2'b10, 1'b0, 5'd3}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic drive(input tv_t v);
      id_instr = v.instr; ex_rs = v.ers; ex_rt = v.ert; ex_is_load = v.ld;
      exm_dst = v.xd; exm_wen = v.xw; mwb_dst = v.wd; mwb_wen = v.ww;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      drive('0);
      @(posedge clk); #1;
      // reset-like idle state: all-zero inputs
      check("R1", "idle sel_a", 32'(sel_a), 32'd0);
      check("R1", "idle sel_b", 32'(sel_b), 32'd0);
      check("R8", "idle hold", 32'(hold_front), 32'd0);
      check("R8", "idle bubble", 32'(bubble_idex), 32'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(TBL[i]);
         @(posedge clk); #1;
         check("R2", $sformatf("vec %0d sel_a", i), 32'(sel_a), 32'(TBL[i].ea));
         check("R3", $sformatf("vec %0d sel_b", i), 32'(sel_b), 32'(TBL[i].eb));
         check("R7", $sformatf("vec %0d hold", i), 32'(hold_front), 32'(TBL[i].es));
         check("R8", $sformatf("vec %0d bubble", i), 32'(bubble_idex), 32'(TBL[i].es));
         check("R10", $sformatf("vec %0d id_dst", i), 32'(id_dst), 32'(TBL[i].ed));
      end

      // R5 and R2 sweep: every register forwarded from execute/memory except 0
      for (int r = 0; r < 32; r++) begin
         @(negedge clk);
         drive('0);
         ex_rs = 5'(r); ex_rt = 5'(r); exm_dst = 5'(r); exm_wen = 1'b1;
         mwb_dst = 5'(r); mwb_wen = 1'b1;
         @(posedge clk); #1;
         check("R5", $sformatf("sweep %0d sel_a", r), 32'(sel_a), (r == 0) ? 32'd0 : 32'd2);
         check("R4", $sformatf("sweep %0d sel_b", r), 32'(sel_b), (r == 0) ? 32'd0 : 32'd2);
      end

      // R9 sweep: an immediate-format op with only an rt match never stalls
      for (int k = 6; k < 16; k++) begin
         @(negedge clk);
         drive('0);
         id_instr = mk(6'(k), 5'd3, 5'd12, 5'd0);
         ex_is_load = 1'b1; ex_rt = 5'd12;
         @(posedge clk); #1;
         check("R9", $sformatf("op %0h hold", k), 32'(hold_front), 32'd0);
      end

      summary();
      $finish;
   end
endmodule